// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks an external SDRAM through its start-up procedure after reset. A single start pulse launches it. It then issues a fixed series of command requests to a downstream command engine, which handles the pin-level timing. The series is: enable the memory clock, wait for the power-up delay, precharge all banks, run one batched auto-refresh, and load the mode register. After each request the sequencer waits for the engine's done handshake. Once the mode register is loaded, it hands the refresh interval to the refresh timer with a one-cycle load strobe. It then raises a sticky init-done flag.

The power-up delay is given in nanoseconds. It is rounded up to whole microseconds and counted in controller clock cycles, using a cycles-per-microsecond parameter. The following inputs are captured on the start pulse and are fixed for the rest of the sequence:

- the delay in nanoseconds;
- the mode-register value;
- the refresh interval;
- the target-bank selection.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the request valid, refresh-load strobe and init-done outputs are all low, and they stay low until a start pulse is seen.
- R2: Request codes are issued in the order 1 (clock enable), 2 (precharge all), 3 (auto-refresh), 4 (load mode register). Each request appears exactly once per sequence.
- R3: While a request is valid and done has not been sampled, the valid signal, code, repeat count, mode data and bank mask do not change.
- R4: The precharge request becomes valid exactly W+1 cycles after the edge that samples done for the clock-enable request. Here W = ceil(ns/1000) x CYC_PER_US, and W is 0 when the delay is 0.
- R5: The auto-refresh request carries a repeat count of 8. Every other request carries a repeat count of 1.
- R6: The load-mode request carries the mode value captured at start as its payload. Every other request carries zero mode data.
- R7: Every request carries the bank mask captured at start. Bit 1 selects bank 1 and bit 0 selects bank 2, so 10 means bank 1, 01 means bank 2 and 11 means both. Changing the bank or mode inputs after start has no effect.
- R8: In the cycle after done is sampled for the load-mode request, the refresh-load strobe is high for exactly one cycle and carries the interval captured at start. During that cycle no request is valid and init-done is low.
- R9: Init-done rises in the cycle after the refresh-load strobe and stays high until reset.
- R10: A start pulse is ignored while the sequence runs and after it has finished. It neither restarts nor repeats any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; sampled only when idle |
| wait_ns_i | input | NS_W | Power-up delay in nanoseconds |
| mode_val_i | input | MODE_W | Mode-register value |
| rfsh_cnt_i | input | RFSH_W | Refresh interval for the refresh timer |
| bank_sel_i | input | 2 | Target-bank mask (bit 1 bank 1, bit 0 bank 2) |
| cmd_done_i | input | 1 | Command engine done pulse |
| cmd_valid_o | output | 1 | Request valid |
| cmd_code_o | output | 3 | Request command code |
| cmd_rep_o | output | REP_W | Repeat count of the request |
| cmd_mode_o | output | MODE_W | Mode data of the request |
| cmd_bank_o | output | 2 | Bank mask of the request |
| rfsh_load_o | output | 1 | One-cycle refresh-timer load strobe |
| rfsh_val_o | output | RFSH_W | Refresh interval carried with the strobe |
| init_done_o | output | 1 | Initialization complete, sticky |

## Verification
The hardest condition to reach from the ports is the exact length of the power-up wait. The wait depends on rounding the nanosecond delay up to whole microseconds, so the bench drives delays of 0, 1, exactly 1000, 1001 and just under a multiple of 1000. It also drives random values. For each delay it counts the cycles from the clock-enable handshake to the precharge request. The bench also delays each done pulse by a random number of cycles. While a request is held, it changes the bank and mode inputs and pulses start, which shows that captured values and the running sequence are not disturbed.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_CLK_EN    = 3'd1;
  localparam logic [CODE_W-1:0] CODE_PRECH_ALL = 3'd2;
  localparam logic [CODE_W-1:0] CODE_AUTO_REF  = 3'd3;
  localparam logic [CODE_W-1:0] CODE_LOAD_MODE = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CKE,
    ST_WAIT,
    ST_PALL,
    ST_AREF,
    ST_LMR,
    ST_ARM,
    ST_DONE
  } seq_st_t;
endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int NS_W       = 20,
  parameter int CYC_PER_US = 100,
  parameter int NS_PER_US  = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [NS_W-1:0] ns_i,
  output logic            busy_o
);
  localparam int CYC_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [NS_W-1:0]  US_NS    = NS_W'(NS_PER_US);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_US - 1);

  logic [NS_W-1:0]  ns_left;
  logic [CYC_W-1:0] cyc_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o  <= 1'b0;
      ns_left <= '0;
      cyc_cnt <= '0;
    end else if (load_i) begin
      busy_o  <= (ns_i != '0);
      ns_left <= ns_i;
      cyc_cnt <= '0;
    end else if (busy_o) begin
      if (cyc_cnt == CYC_LAST) begin
        cyc_cnt <= '0;
        if (ns_left <= US_NS) begin
          busy_o  <= 1'b0;
          ns_left <= '0;
        end else begin
          ns_left <= ns_left - US_NS;
        end
      end else begin
        cyc_cnt <= cyc_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_init_req.sv
module sdram_init_req
  import sdram_init_pkg::*;
#(
  parameter int MODE_W     = 16,
  parameter int RFSH_W     = 13,
  parameter int AREF_COUNT = 8,
  parameter int REP_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_st_t           nxt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        bank_i,
  input  logic [RFSH_W-1:0] rfsh_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic [REP_W-1:0]  rep_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [1:0]        bank_o,
  output logic              rfsh_load_o,
  output logic [RFSH_W-1:0] rfsh_val_o,
  output logic              done_o
);
  logic              nv;
  logic [CODE_W-1:0] ncode;
  logic [REP_W-1:0]  nrep;
  logic [MODE_W-1:0] nmode;

  always_comb begin
    nv    = 1'b1;
    ncode = '0;
    nrep  = REP_W'(1);
    nmode = '0;
    unique case (nxt_i)
      ST_CKE:  ncode = CODE_CLK_EN;
      ST_PALL: ncode = CODE_PRECH_ALL;
      ST_AREF: begin
        ncode = CODE_AUTO_REF;
        nrep  = REP_W'(AREF_COUNT);
      end
      ST_LMR: begin
        ncode = CODE_LOAD_MODE;
        nmode = mode_i;
      end
      default: begin
        nv   = 1'b0;
        nrep = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o     <= 1'b0;
      code_o      <= '0;
      rep_o       <= '0;
      mode_o      <= '0;
      bank_o      <= '0;
      rfsh_load_o <= 1'b0;
      rfsh_val_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      valid_o     <= nv;
      code_o      <= ncode;
      rep_o       <= nrep;
      mode_o      <= nmode;
      bank_o      <= nv ? bank_i : 2'b00;
      rfsh_load_o <= (nxt_i == ST_ARM);
      rfsh_val_o  <= (nxt_i == ST_ARM) ? rfsh_i : '0;
      done_o      <= (nxt_i == ST_DONE);
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int NS_W       = 20,
  parameter int MODE_W     = 16,
  parameter int RFSH_W     = 13,
  parameter int CYC_PER_US = 100,
  parameter int NS_PER_US  = 1000,
  parameter int AREF_COUNT = 8,
  localparam int REP_W     = $clog2(AREF_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [NS_W-1:0]   wait_ns_i,
  input  logic [MODE_W-1:0] mode_val_i,
  input  logic [RFSH_W-1:0] rfsh_cnt_i,
  input  logic [1:0]        bank_sel_i,
  input  logic              cmd_done_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_code_o,
  output logic [REP_W-1:0]  cmd_rep_o,
  output logic [MODE_W-1:0] cmd_mode_o,
  output logic [1:0]        cmd_bank_o,
  output logic              rfsh_load_o,
  output logic [RFSH_W-1:0] rfsh_val_o,
  output logic              init_done_o
);
  seq_st_t           st_q, st_d;
  logic [NS_W-1:0]   ns_q;
  logic [MODE_W-1:0] mode_q;
  logic [RFSH_W-1:0] rfsh_q;
  logic [1:0]        bank_q;
  logic [1:0]        bank_eff;
  logic              tmr_load, tmr_busy;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i)    st_d = ST_CKE;
      ST_CKE:  if (cmd_done_i) st_d = ST_WAIT;
      ST_WAIT: if (!tmr_busy)  st_d = ST_PALL;
      ST_PALL: if (cmd_done_i) st_d = ST_AREF;
      ST_AREF: if (cmd_done_i) st_d = ST_LMR;
      ST_LMR:  if (cmd_done_i) st_d = ST_ARM;
      ST_ARM:                  st_d = ST_DONE;
      default:                 st_d = ST_DONE;
    endcase
  end

  assign tmr_load = (st_q == ST_CKE) && cmd_done_i;
  assign bank_eff = (st_q == ST_IDLE) ? bank_sel_i : bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ns_q   <= '0;
      mode_q <= '0;
      rfsh_q <= '0;
      bank_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        ns_q   <= wait_ns_i;
        mode_q <= mode_val_i;
        rfsh_q <= rfsh_cnt_i;
        bank_q <= bank_sel_i;
      end
    end
  end

  sdram_init_timer #(
    .NS_W(NS_W), .CYC_PER_US(CYC_PER_US), .NS_PER_US(NS_PER_US)
  ) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load), .ns_i(ns_q), .busy_o(tmr_busy)
  );

  sdram_init_req #(
    .MODE_W(MODE_W), .RFSH_W(RFSH_W), .AREF_COUNT(AREF_COUNT), .REP_W(REP_W)
  ) u_req (
    .clk(clk), .rst(rst), .nxt_i(st_d), .mode_i(mode_q), .bank_i(bank_eff),
    .rfsh_i(rfsh_q), .valid_o(cmd_valid_o), .code_o(cmd_code_o),
    .rep_o(cmd_rep_o), .mode_o(cmd_mode_o), .bank_o(cmd_bank_o),
    .rfsh_load_o(rfsh_load_o), .rfsh_val_o(rfsh_val_o), .done_o(init_done_o)
  );
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int MODE_W = 16,
  parameter int REP_W  = 4,
  parameter int AREF_COUNT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_done_i,
  input logic              cmd_valid_o,
  input logic [2:0]        cmd_code_o,
  input logic [REP_W-1:0]  cmd_rep_o,
  input logic [MODE_W-1:0] cmd_mode_o,
  input logic [1:0]        cmd_bank_o,
  input logic              rfsh_load_o,
  input logic              init_done_o
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_code_o) && $stable(cmd_rep_o)
      && $stable(cmd_mode_o) && $stable(cmd_bank_o)); // R3
  AST_AREF_REP: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && cmd_code_o == 3'd3 |-> cmd_rep_o == REP_W'(AREF_COUNT)); // R5
  AST_MODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && cmd_code_o != 3'd4 |-> cmd_mode_o == '0); // R6
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rfsh_load_o |=> !rfsh_load_o && init_done_o); // R8
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    rfsh_load_o |-> !cmd_valid_o && !init_done_o); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done_o |=> init_done_o); // R9
  AST_NO_REQ_AFTER: assert property (@(posedge clk) disable iff (rst)
    init_done_o |-> !cmd_valid_o); // R10
endmodule

bind sdram_init_seq sdram_init_chk #(
  .MODE_W(MODE_W), .REP_W(REP_W), .AREF_COUNT(AREF_COUNT)
) u_chk (
  .clk(clk), .rst(rst), .cmd_done_i(cmd_done_i), .cmd_valid_o(cmd_valid_o),
  .cmd_code_o(cmd_code_o), .cmd_rep_o(cmd_rep_o), .cmd_mode_o(cmd_mode_o),
  .cmd_bank_o(cmd_bank_o), .rfsh_load_o(rfsh_load_o), .init_done_o(init_done_o)
);

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;
  localparam int NS_W = 20, MODE_W = 16, RFSH_W = 13, CPU = 4, REP_W = 4;

  logic clk = 0, rst = 1, start_i = 0, cmd_done_i = 0;
  logic [NS_W-1:0] wait_ns_i = '0;
  logic [MODE_W-1:0] mode_val_i = '0;
  logic [RFSH_W-1:0] rfsh_cnt_i = '0;
  logic [1:0] bank_sel_i = 2'b10;
  logic cmd_valid_o, rfsh_load_o, init_done_o;
  logic [2:0] cmd_code_o;
  logic [REP_W-1:0] cmd_rep_o;
  logic [MODE_W-1:0] cmd_mode_o;
  logic [1:0] cmd_bank_o;
  logic [RFSH_W-1:0] rfsh_val_o;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(.NS_W(NS_W), .MODE_W(MODE_W), .RFSH_W(RFSH_W), .CYC_PER_US(CPU))
  i_sdram_init_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .wait_ns_i(wait_ns_i),
    .mode_val_i(mode_val_i), .rfsh_cnt_i(rfsh_cnt_i), .bank_sel_i(bank_sel_i),
    .cmd_done_i(cmd_done_i), .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
    .cmd_rep_o(cmd_rep_o), .cmd_mode_o(cmd_mode_o), .cmd_bank_o(cmd_bank_o),
    .rfsh_load_o(rfsh_load_o), .rfsh_val_o(rfsh_val_o), .init_done_o(init_done_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_wait(input int ns);
    return ((ns + 999) / 1000) * CPU;
  endfunction

  function automatic int exp_rep(input int code);
    return (code == 3) ? 8 : 1;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Handles one request at a negedge: checks fields, holds, then pulses done.
  task automatic serve(input int code, input logic [1:0] bank, input logic [MODE_W-1:0] mode,
                       input bit disturb);
    int guard = 0;
    while (!cmd_valid_o && guard < 1000) begin @(negedge clk); guard++; end
    check("R2 code order", cmd_code_o, code);
    check("R5 repeat", cmd_rep_o, exp_rep(code));
    check("R6 mode payload", cmd_mode_o, (code == 4) ? mode : 0);
    check("R7 bank mask", cmd_bank_o, bank);
    for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
      if (disturb) begin
        bank_sel_i = 2'($urandom); mode_val_i = 16'($urandom); start_i = 1;
      end
      @(negedge clk);
      start_i = 0;
      check("R3 held valid", cmd_valid_o, 1);
      check("R3 held code", cmd_code_o, code);
    end
    cmd_done_i = 1;
    @(negedge clk);
    cmd_done_i = 0;
  endtask

  task automatic run(input int ns, input bit disturb);
    logic [1:0] bank;
    logic [MODE_W-1:0] mode;
    logic [RFSH_W-1:0] rf;
    int cnt;
    bank = ($urandom_range(0, 2) == 0) ? 2'b11 : (($urandom & 1) ? 2'b10 : 2'b01);
    mode = 16'($urandom);
    rf = 13'($urandom);
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset valid", cmd_valid_o, 0);
    check("R1 reset done", init_done_o, 0);
    check("R1 reset load", rfsh_load_o, 0);
    wait_ns_i = NS_W'(ns); bank_sel_i = bank; mode_val_i = mode; rfsh_cnt_i = rf;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_ns_i = NS_W'($urandom);
    serve(1, bank, mode, disturb);
    cnt = 0;
    while (!cmd_valid_o && cnt < 100000) begin cnt++; @(negedge clk); end
    check("R4 startup wait cycles", cnt, exp_wait(ns) + 1);
    serve(2, bank, mode, disturb);
    serve(3, bank, mode, disturb);
    serve(4, bank, mode, disturb);
    check("R8 load strobe", rfsh_load_o, 1);
    check("R8 load value", rfsh_val_o, rf);
    check("R8 no request", cmd_valid_o, 0);
    check("R8 done still low", init_done_o, 0);
    @(negedge clk);
    check("R8 strobe one cycle", rfsh_load_o, 0);
    check("R9 init done", init_done_o, 1);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R10 no restart", cmd_valid_o, 0);
      check("R9 done sticky", init_done_o, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5D12));
    @(negedge clk); @(negedge clk);
    check("R1 valid in reset", cmd_valid_o, 0);
    rst = 0;
    start_i = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 idle without start", cmd_valid_o, 0);
    end
    run(0, 0);
    run(1, 0);
    run(1000, 1);
    run(1001, 0);
    run(3999, 1);
    for (int n = 0; n < 10; n++) run(int'($urandom_range(0, 20000)), n[0]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule